// File: doc/BRIEF.md
# Microcoded Shift-and-Add Multiplier Sequencer

This block steers a shift-and-add multiplier datapath from a five-word read-only table of control words. A three-bit state register selects one word; the word's low four bits leave the block as datapath strobes, and the remaining bits pick the next state. Each word names two candidate successors and a two-bit selector that chooses which status bit decides between them: a constant zero, the start request, the current multiplier bit, or the count-done flag. Only the state register is clocked; the table and the successor logic are combinational, and nothing registers the table output.

The strobes depend only on the state (Moore behaviour). The status inputs only choose which successor is loaded at the next clock edge. The named states and their encodings are IDLE (000), INIT (001), MUL0 (010), ADD (011) and MUL1 (100). The transitions are: IDLE to INIT on start, otherwise IDLE holds; INIT to MUL0; MUL0 to ADD when the multiplier bit is 1, otherwise to MUL1; ADD to MUL1; MUL1 to IDLE when the count is done, otherwise back to MUL0. The encodings 101 to 111 hold all-zero words, and an all-zero word returns to IDLE.

Top module: `mpc_mul_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the state goes to IDLE (`ctrl_addr` = 000) and all four strobes are 0.
- R2: In IDLE, no strobe is active. `start_req` = 1 moves to INIT (001), and `start_req` = 0 holds IDLE.
- R3: In INIT, `strobe` = 0101 (bit 0 = initialise, bit 2 = clear carry). The next state is MUL0 (010) whatever the inputs.
- R4: In MUL0, no strobe is active. `mplr_lsb` = 1 moves to ADD (011), and `mplr_lsb` = 0 moves to MUL1 (100).
- R5: In ADD, `strobe` = 0010 (bit 1 = add and load). The next state is MUL1 (100) whatever the inputs.
- R6: In MUL1, `strobe` = 1100 (bit 2 = clear carry, bit 3 = shift and decrement). `count_zero` = 1 moves to IDLE, and `count_zero` = 0 moves to MUL0.
- R7: The strobes are a function of `ctrl_addr` alone. Changing any status input within a cycle leaves `strobe` unchanged.
- R8: A status input that the current state does not test has no effect on the next state.
- R9: `ctrl_addr` never leaves the range 000 to 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to IDLE |
| start_req | input | 1 | Start request, tested in IDLE |
| mplr_lsb | input | 1 | Current multiplier bit, tested in MUL0 |
| count_zero | input | 1 | Bit counter has reached zero, tested in MUL1 |
| strobe | output | 4 | Datapath strobes: bit0 initialise, bit1 add/load, bit2 clear carry, bit3 shift/decrement |
| ctrl_addr | output | 3 | Current state encoding, for observation |

## Verification
The state register is the only storage, and `ctrl_addr` exposes it directly. A wrong successor therefore shows at the port one clock after the faulty transition. The strobe pattern of that wrong state appears in the same cycle. A wrong table word or a misrouted selector shows up as an unexpected strobe pattern in the affected state, or as a wrong successor the first time that state tests its status bit. Driving every branch, including status bits that the current state ignores, is meant to expose each of these faults within one cycle of reaching the faulty state.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
    localparam int ADDR_W  = 3;
    localparam int SEL_W   = 2;
    localparam int STB_W   = 4;
    localparam int WORD_W  = 2 * ADDR_W + SEL_W + STB_W;
    localparam int N_WORDS = 1 << ADDR_W;

    // strobe bit positions
    localparam int STB_INIT  = 0;
    localparam int STB_ADD   = 1;
    localparam int STB_CLRC  = 2;
    localparam int STB_SHIFT = 3;

    typedef enum logic [ADDR_W-1:0] {
        ST_IDLE = 3'd0,
        ST_INIT = 3'd1,
        ST_MUL0 = 3'd2,
        ST_ADD  = 3'd3,
        ST_MUL1 = 3'd4
    } state_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_NONE  = 2'b00,
        SEL_START = 2'b01,
        SEL_LSB   = 2'b10,
        SEL_DONE  = 2'b11
    } cond_sel_t;

    // field order fixes bit positions: 11..9 taken, 8..6 not taken, 5..4 selector, 3..0 strobes
    typedef struct packed {
        logic [ADDR_W-1:0] addr_taken;
        logic [ADDR_W-1:0] addr_fall;
        cond_sel_t         sel;
        logic [STB_W-1:0]  stb;
    } uword_t;
endpackage

// File: rtl/mpc_ctrl_store.sv
module mpc_ctrl_store
    import mpc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output uword_t            word
);
    always_comb begin
        word = '0;
        unique case (addr)
            ST_IDLE: word = '{addr_taken: ST_INIT, addr_fall: ST_IDLE,
                              sel: SEL_START, stb: 4'b0000};
            ST_INIT: word = '{addr_taken: ST_IDLE, addr_fall: ST_MUL0,
                              sel: SEL_NONE,  stb: 4'b0101};
            ST_MUL0: word = '{addr_taken: ST_ADD,  addr_fall: ST_MUL1,
                              sel: SEL_LSB,   stb: 4'b0000};
            ST_ADD:  word = '{addr_taken: ST_IDLE, addr_fall: ST_MUL1,
                              sel: SEL_NONE,  stb: 4'b0010};
            ST_MUL1: word = '{addr_taken: ST_IDLE, addr_fall: ST_MUL0,
                              sel: SEL_DONE,  stb: 4'b1100};
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/mpc_cond_mux.sv
module mpc_cond_mux
    import mpc_pkg::*;
(
    input  cond_sel_t sel,
    input  logic      start_req,
    input  logic      mplr_lsb,
    input  logic      count_zero,
    output logic      cond
);
    localparam int N_SRC = 1 << SEL_W;
    logic [N_SRC-1:0] src;

    assign src = {count_zero, mplr_lsb, start_req, 1'b0};
    assign cond = src[sel];
endmodule

// File: rtl/mpc_next_addr.sv
module mpc_next_addr
    import mpc_pkg::*;
(
    input  uword_t            word,
    input  logic              cond,
    output logic [ADDR_W-1:0] next_addr
);
    assign next_addr = cond ? word.addr_taken : word.addr_fall;
endmodule

// File: rtl/mpc_mul_sequencer.sv
module mpc_mul_sequencer
    import mpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              mplr_lsb,
    input  logic              count_zero,
    output logic [STB_W-1:0]  strobe,
    output logic [ADDR_W-1:0] ctrl_addr
);
    state_t            state_q;
    uword_t            word;
    logic              cond;
    logic [ADDR_W-1:0] next_addr;

    mpc_ctrl_store u_store (
        .addr (state_q),
        .word (word)
    );

    mpc_cond_mux u_cmux (
        .sel        (word.sel),
        .start_req  (start_req),
        .mplr_lsb   (mplr_lsb),
        .count_zero (count_zero),
        .cond       (cond)
    );

    mpc_next_addr u_next (
        .word      (word),
        .cond      (cond),
        .next_addr (next_addr)
    );

    // state register: the only clocked element
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_t'(next_addr);
    end

    // outputs come straight from the current word
    always_comb begin
        strobe    = word.stb;
        ctrl_addr = state_q;
    end
endmodule

// File: rtl/mpc_seq_checker.sv
module mpc_seq_checker
    import mpc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_req,
    input logic              mplr_lsb,
    input logic              count_zero,
    input logic [STB_W-1:0]  strobe,
    input logic [ADDR_W-1:0] ctrl_addr
);
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (ctrl_addr == 3'd0 && strobe == 4'd0)); // R1
    AST_IDLE_GO: assert property (@(posedge clk) disable iff (rst)
        (ctrl_addr == 3'd0 && start_req) |=> ctrl_addr == 3'd1); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctrl_addr == 3'd0 && !start_req) |=> ctrl_addr == 3'd0); // R2
    AST_INIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (ctrl_addr == 3'd1) |=> ctrl_addr == 3'd2); // R3
    AST_INIT_STB: assert property (@(posedge clk) disable iff (rst)
        (ctrl_addr == 3'd1) |-> strobe == 4'b0101); // R3
    AST_MUL0_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (ctrl_addr == 3'd2) |=> ctrl_addr == ($past(mplr_lsb) ? 3'd3 : 3'd4)); // R4
    AST_ADD_STEP: assert property (@(posedge clk) disable iff (rst)
        (ctrl_addr == 3'd3) |=> ctrl_addr == 3'd4); // R5
    AST_MUL1_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (ctrl_addr == 3'd4) |=> ctrl_addr == ($past(count_zero) ? 3'd0 : 3'd2)); // R6
    AST_MOORE_STB: assert property (@(posedge clk) disable iff (rst)
        $stable(ctrl_addr) |-> $stable(strobe)); // R7
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
        ctrl_addr <= 3'd4); // R9
endmodule

bind mpc_mul_sequencer mpc_seq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_req  (start_req),
    .mplr_lsb   (mplr_lsb),
    .count_zero (count_zero),
    .strobe     (strobe),
    .ctrl_addr  (ctrl_addr)
);

// File: tb/tb_mpc_mul_sequencer.sv
module tb_mpc_mul_sequencer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_req = 1'b0;
    logic       mplr_lsb = 1'b0;
    logic       count_zero = 1'b0;
    logic [3:0] strobe;
    logic [2:0] ctrl_addr;
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    mpc_mul_sequencer dut (
        .clk(clk), .rst(rst), .start_req(start_req), .mplr_lsb(mplr_lsb),
        .count_zero(count_zero), .strobe(strobe), .ctrl_addr(ctrl_addr)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // one clock edge, then settle away from it
    task automatic tick();
        @(posedge clk);
        #5;
        check("R9 range", {1'b0, ctrl_addr <= 3'd4 ? 3'd1 : 3'd0}, 4'd1);
    endtask

    task automatic expect_state(input string req, input logic [2:0] a, input logic [3:0] s);
        check({req, " addr"}, {1'b0, ctrl_addr}, {1'b0, a});
        check({req, " strobe"}, strobe, s);
    endtask

    task automatic t_reset();
        rst = 1'b1; start_req = 1'b1;
        tick(); tick();
        expect_state("R1", 3'd0, 4'b0000);
        rst = 1'b0; start_req = 1'b0;
    endtask

    task automatic t_idle_hold();
        start_req = 1'b0; mplr_lsb = 1'b1; count_zero = 1'b1;   // R8 untested inputs
        for (int i = 0; i < 3; i++) begin
            tick();
            expect_state("R2 R8 idle hold", 3'd0, 4'b0000);
        end
    endtask

    // full multiply walk over a multiplier bit pattern, lsb first
    task automatic t_run(input int nbits, input logic [7:0] pattern);
        start_req = 1'b1; count_zero = 1'b0;
        tick();
        expect_state("R2 start", 3'd1, 4'b0101);
        check("R3 init strobe", strobe, 4'b0101);
        mplr_lsb = 1'b0; count_zero = 1'b1;   // R8 ignored in INIT
        tick();
        expect_state("R3 to MUL0", 3'd2, 4'b0000);
        start_req = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            mplr_lsb = pattern[i];
            start_req = 1'b1; count_zero = 1'b1;   // R8 ignored in MUL0
            tick();
            if (pattern[i]) begin
                expect_state("R4 to ADD", 3'd3, 4'b0010);
                mplr_lsb = 1'b0; count_zero = 1'b0;  // R8 ignored in ADD
                tick();
                expect_state("R5 to MUL1", 3'd4, 4'b1100);
            end else begin
                expect_state("R4 to MUL1", 3'd4, 4'b1100);
            end
            // R7: status toggles inside the cycle leave strobes unchanged
            start_req = ~start_req; mplr_lsb = ~mplr_lsb;
            #2;
            check("R7 moore", strobe, 4'b1100);
            start_req = 1'b0;
            count_zero = (i == nbits - 1);
            tick();
            if (i == nbits - 1) expect_state("R6 to IDLE", 3'd0, 4'b0000);
            else                expect_state("R6 to MUL0", 3'd2, 4'b0000);
        end
    endtask

    task automatic t_reset_midrun();
        start_req = 1'b1;
        tick(); tick();
        rst = 1'b1;
        tick();
        expect_state("R1 mid-run", 3'd0, 4'b0000);
        rst = 1'b0; start_req = 1'b0;
        tick();
        expect_state("R1 after", 3'd0, 4'b0000);
    endtask

    initial begin
        #(20 * 5000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #3;
        t_reset();
        t_idle_hold();
        t_run(4, 8'b1011);
        t_idle_hold();
        t_run(3, 8'b000);
        t_run(5, 8'b11111);
        t_run(1, 8'b0);
        t_reset_midrun();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule